// File: doc/BRIEF.md
# PWM Output Standby Sequencer

This block sequences one stereo PWM output pair between standby and full operation. It decides when the output stage is enabled, which waveform the output drivers carry (held at ground, a 50% bipolar-zero square wave, or the modulated signal), and what gain the mute stage applies. All phase timing is counted in sample periods, marked by a one-cycle Fs tick. The only exception is the emergency stop, which acts within a few system clocks.

Control comes from three active-low pins and a set of firmware inputs. The pins request standby, request mute, and request an error stop. Each pin has its own firmware mask. The firmware inputs are an activate/standby level, a stop command, a noise-suppression enable, and a bipolar-zero extension enable.

A shutdown runs through these phases in order:
1. The gain ramps down to zero.
2. An optional modulator-clear interval follows.
3. A bipolar-zero interval follows. At its end the enable flag drops.
4. With the extension enabled, a further bipolar-zero interval follows while the enable flag is low.

An activation that arrives during a shutdown waits until the sequence has reached standby.

Top module: `pwm_stby_seq`

## Requirements
- R1: After reset the enable flag is 0, the output mode is ground (code 0) and the gain is 0.
- R2: From standby with the extension off, a high activate level (with no standby request) raises the enable flag at the next clock edge. The mode becomes modulated (code 2) and the gain stays 0 for ACT_DLY_TICKS ticks.
- R3: After that delay the gain rises by one per tick up to RAMP_TICKS (full scale) and holds there.
- R4: Phase counters and the gain change only on clock edges where the Fs tick is high.
- R5: While running, an unmasked low on the mute pin lowers the gain by one per tick toward 0 and the enable flag stays high. Releasing the pin ramps the gain back up by one per tick.
- R6: A standby request (activate level low, or an unmasked low on the standby pin) lowers the gain by one per tick. The mute phase ends on the tick at which the gain is 1 or less, so it lasts at most RAMP_TICKS ticks.
- R7: With noise suppression on, a clear phase of CLR_TICKS ticks follows the mute phase, with the enable flag high, the mode modulated and the gain 0. With noise suppression off, the clear phase is skipped.
- R8: The bipolar-zero phase (mode code 1, enable flag high) lasts BPZ_TICKS ticks. With the extension off, the enable flag then falls and the mode goes to ground at the same edge.
- R9: With the extension on, an activation first spends EXT_TICKS ticks with the enable flag low and mode bipolar-zero. A shutdown likewise ends with EXT_TICKS ticks of enable low and bipolar-zero before ground.
- R10: An unmasked low on the error pin, or the firmware stop, forces the enable flag low, the mode to ground and the gain to 0 from any phase. This happens at the third clock edge for the pin and at the next edge for firmware, independent of the tick. The block stays stopped while the request is active and returns to standby when it is released.
- R11: An activate level seen during a shutdown phase does not interrupt the sequence. The block reaches standby and then starts the activation at the following clock edge.
- R12: Each of the three pins is ignored while its mask input is 1.
- R13: Each pin passes through a two-stage synchronizer, so a pin change has no effect on the outputs before the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_tick_i | input | 1 | One-cycle pulse per sample period |
| stby_req_ni | input | 1 | Standby request pin, active low, asynchronous |
| mute_req_ni | input | 1 | Mute request pin, active low, asynchronous |
| err_stop_ni | input | 1 | Error-stop pin, active low, asynchronous |
| mask_stby_i | input | 1 | Ignore the standby pin when 1 |
| mask_mute_i | input | 1 | Ignore the mute pin when 1 |
| mask_err_i | input | 1 | Ignore the error-stop pin when 1 |
| fw_active_i | input | 1 | Firmware level: 1 requests operation, 0 requests standby |
| fw_stop_i | input | 1 | Firmware emergency stop |
| nsup_en_i | input | 1 | Enables the modulator-clear phase on shutdown |
| bpz_ext_i | input | 1 | Enables bipolar-zero intervals while the enable flag is low |
| pwm_en_o | output | 1 | Output-stage enable flag |
| out_mode_o | output | 2 | Output waveform: 0 ground, 1 bipolar zero, 2 modulated |
| gain_o | output | GAIN_W | Mute-stage gain, 0 to RAMP_TICKS |

## Verification
The embedded properties are checked on every cycle:
- a modulated mode only ever appears with the enable flag high;
- the enable flag only rises while the gain is zero;
- an error request always produces the stopped outputs at the next edge;
- the gain never moves without a tick and never passes full scale;
- the enable flag only falls out of the bipolar-zero phase;
- a shutdown phase never goes straight back to an active phase.

The exact lengths of each phase, the effect of each pin mask, the synchronizer latency, the extension intervals and the deferred activation can only be shown by the bench's scenarios. The bench sweeps through these tick by tick against counts it computes itself.

// File: rtl/pwm_stby_pkg.sv
package pwm_stby_pkg;

  typedef enum logic [1:0] {
    MODE_GND = 2'd0,
    MODE_BPZ = 2'd1,
    MODE_MOD = 2'd2
  } out_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_PRE   = 4'd1,
    ST_START = 4'd2,
    ST_RUN   = 4'd3,
    ST_MUTE  = 4'd4,
    ST_CLEAR = 4'd5,
    ST_BPZ   = 4'd6,
    ST_POST  = 4'd7,
    ST_STOP  = 4'd8
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_stby_rst_sync.sv
module pwm_stby_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_stby_sync.sv
module pwm_stby_sync #(
  parameter int unsigned     W       = 3,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end

    assign q_o[b] = sync_q;
  end

endmodule

// File: rtl/pwm_stby_phase_cnt.sv
module pwm_stby_phase_cnt #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             last_w;

  assign last_w = (cnt_q == (limit_i - 1'b1));
  assign done_o = tick_i & last_w;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = last_w ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4: the phase count stays inside the current phase length
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);

  // R4: without a tick or a clear the count does not move
  p_cnt_tick_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_stby_gain.sv
module pwm_stby_gain #(
  parameter int unsigned FULL = 1024,
  parameter int unsigned W    = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] gain_o,
  output logic         low_o
);

  localparam logic [W-1:0] GAIN_FULL = W'(FULL);

  logic [W-1:0] gain_q;
  logic [W-1:0] gain_d;

  always_comb begin
    gain_d = gain_q;
    if (clr_i) begin
      gain_d = '0;
    end else if (tick_i) begin
      if (dn_i && (gain_q != '0))             gain_d = gain_q - 1'b1;
      else if (up_i && (gain_q != GAIN_FULL)) gain_d = gain_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= '0;
    else         gain_q <= gain_d;
  end

  assign gain_o = gain_q;
  assign low_o  = (gain_q <= W'(1));

  // R3: gain never exceeds full scale
  p_gain_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_q <= GAIN_FULL);

  // R4: gain only moves on a tick unless forced to zero
  p_gain_tick_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(gain_q));

endmodule

// File: rtl/pwm_stby_seq.sv
module pwm_stby_seq
  import pwm_stby_pkg::*;
#(
  parameter int unsigned ACT_DLY_TICKS = 720,
  parameter int unsigned RAMP_TICKS    = 1024,
  parameter int unsigned CLR_TICKS     = 65536,
  parameter int unsigned BPZ_TICKS     = 256,
  parameter int unsigned EXT_TICKS     = 384,
  parameter int unsigned GAIN_W        = $clog2(RAMP_TICKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_tick_i,
  input  logic              stby_req_ni,
  input  logic              mute_req_ni,
  input  logic              err_stop_ni,
  input  logic              mask_stby_i,
  input  logic              mask_mute_i,
  input  logic              mask_err_i,
  input  logic              fw_active_i,
  input  logic              fw_stop_i,
  input  logic              nsup_en_i,
  input  logic              bpz_ext_i,
  output logic              pwm_en_o,
  output logic [1:0]        out_mode_o,
  output logic [GAIN_W-1:0] gain_o
);

  localparam int unsigned MAX_LEN =
    max_u(max_u(ACT_DLY_TICKS, CLR_TICKS), max_u(BPZ_TICKS, EXT_TICKS));
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  localparam int unsigned PIN_STBY = 0;
  localparam int unsigned PIN_MUTE = 1;
  localparam int unsigned PIN_ERR  = 2;

  // reset release and pin synchronizers
  logic       rst_n;
  logic [2:0] pin_raw;
  logic [2:0] pin_s;

  pwm_stby_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign pin_raw[PIN_STBY] = stby_req_ni;
  assign pin_raw[PIN_MUTE] = mute_req_ni;
  assign pin_raw[PIN_ERR]  = err_stop_ni;

  pwm_stby_sync #(.W(3), .RST_VAL(3'b111)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (pin_raw),
    .q_o    (pin_s)
  );

  // request decode
  logic stby_pin_req;
  logic mute_req;
  logic err_req;
  logic want_act;

  assign stby_pin_req = ~pin_s[PIN_STBY] & ~mask_stby_i;
  assign mute_req     = ~pin_s[PIN_MUTE] & ~mask_mute_i;
  assign err_req      = (~pin_s[PIN_ERR] & ~mask_err_i) | fw_stop_i;
  assign want_act     = fw_active_i & ~stby_pin_req;

  // state register, counter and gain
  seq_state_e       state_q;
  seq_state_e       state_d;
  logic [CNT_W-1:0] phase_len;
  logic             phase_done;
  logic             cnt_clr;
  logic             gain_clr;
  logic             gain_up;
  logic             gain_dn;
  logic             gain_low;

  assign cnt_clr = (state_d != state_q);

  always_comb begin
    case (state_q)
      ST_PRE,
      ST_POST:  phase_len = CNT_W'(EXT_TICKS);
      ST_START: phase_len = CNT_W'(ACT_DLY_TICKS);
      ST_CLEAR: phase_len = CNT_W'(CLR_TICKS);
      ST_BPZ:   phase_len = CNT_W'(BPZ_TICKS);
      default:  phase_len = CNT_W'(1);
    endcase
  end

  pwm_stby_phase_cnt #(.CNT_W(CNT_W)) u_phase_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (cnt_clr),
    .tick_i  (fs_tick_i),
    .limit_i (phase_len),
    .done_o  (phase_done)
  );

  assign gain_clr = (state_d == ST_IDLE) || (state_d == ST_PRE) || (state_d == ST_STOP);
  assign gain_up  = (state_q == ST_RUN) && !mute_req;
  assign gain_dn  = ((state_q == ST_RUN) && mute_req) || (state_q == ST_MUTE);

  pwm_stby_gain #(.FULL(RAMP_TICKS), .W(GAIN_W)) u_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (fs_tick_i),
    .clr_i  (gain_clr),
    .up_i   (gain_up),
    .dn_i   (gain_dn),
    .gain_o (gain_o),
    .low_o  (gain_low)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (err_req) begin
      state_d = ST_STOP;
    end else begin
      case (state_q)
        ST_IDLE:  if (want_act) state_d = bpz_ext_i ? ST_PRE : ST_START;
        ST_PRE:   if (!want_act)      state_d = ST_IDLE;
                  else if (phase_done) state_d = ST_START;
        ST_START: if (!want_act)      state_d = ST_MUTE;
                  else if (phase_done) state_d = ST_RUN;
        ST_RUN:   if (!want_act)      state_d = ST_MUTE;
        ST_MUTE:  if (fs_tick_i && gain_low) state_d = nsup_en_i ? ST_CLEAR : ST_BPZ;
        ST_CLEAR: if (phase_done)     state_d = ST_BPZ;
        ST_BPZ:   if (phase_done)     state_d = bpz_ext_i ? ST_POST : ST_IDLE;
        ST_POST:  if (phase_done)     state_d = ST_IDLE;
        ST_STOP:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // output decode
  out_mode_e mode_w;

  always_comb begin
    case (state_q)
      ST_START, ST_RUN, ST_MUTE, ST_CLEAR: begin
        pwm_en_o = 1'b1;
        mode_w   = MODE_MOD;
      end
      ST_BPZ: begin
        pwm_en_o = 1'b1;
        mode_w   = MODE_BPZ;
      end
      ST_PRE, ST_POST: begin
        pwm_en_o = 1'b0;
        mode_w   = MODE_BPZ;
      end
      default: begin
        pwm_en_o = 1'b0;
        mode_w   = MODE_GND;
      end
    endcase
  end

  assign out_mode_o = mode_w;

  // R2: modulated output only with the enable flag high
  p_mod_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (out_mode_o == MODE_MOD) |-> pwm_en_o);

  // R2: the enable flag rises only with the gain at zero
  p_en_rise_mute_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(pwm_en_o) |-> (gain_o == '0));

  // R10: an error request stops the outputs at the next edge
  p_stop_fast_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_req |=> (!pwm_en_o && (out_mode_o == MODE_GND) && (gain_o == '0)));

  // R8: outside an error stop the enable flag falls only out of the bipolar-zero phase
  p_en_fall_bpz_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(pwm_en_o) && (state_q != ST_STOP)) |-> ($past(state_q) == ST_BPZ));

  // R11: a shutdown phase never jumps back into an active phase
  p_hold_act_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state_q == ST_MUTE) || (state_q == ST_CLEAR) || (state_q == ST_BPZ) ||
     (state_q == ST_POST)) |=> ((state_q != ST_START) && (state_q != ST_RUN)));

endmodule

// File: tb/test_pwm_stby_seq.sv
module test_pwm_stby_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ACT  = 6;
  localparam int RAMP = 8;
  localparam int CLR  = 5;
  localparam int BPZ  = 4;
  localparam int EXT  = 3;
  localparam int GW   = $clog2(RAMP + 1);
  localparam int M_GND = 0;
  localparam int M_BPZ = 1;
  localparam int M_MOD = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fs_tick;
  logic          stby_n, mute_n, err_n;
  logic          mask_stby, mask_mute, mask_err;
  logic          fw_active, fw_stop, nsup_en, bpz_ext;
  logic          pwm_en;
  logic [1:0]    out_mode;
  logic [GW-1:0] gain;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_stby_seq #(
    .ACT_DLY_TICKS (ACT),
    .RAMP_TICKS    (RAMP),
    .CLR_TICKS     (CLR),
    .BPZ_TICKS     (BPZ),
    .EXT_TICKS     (EXT)
  ) i_pwm_stby_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fs_tick_i   (fs_tick),
    .stby_req_ni (stby_n),
    .mute_req_ni (mute_n),
    .err_stop_ni (err_n),
    .mask_stby_i (mask_stby),
    .mask_mute_i (mask_mute),
    .mask_err_i  (mask_err),
    .fw_active_i (fw_active),
    .fw_stop_i   (fw_stop),
    .nsup_en_i   (nsup_en),
    .bpz_ext_i   (bpz_ext),
    .pwm_en_o    (pwm_en),
    .out_mode_o  (out_mode),
    .gain_o      (gain)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int en, input int md, input int g);
    check({req, " enable"}, int'(pwm_en), en);
    check({req, " mode"}, int'(out_mode), md);
    if (g >= 0) check({req, " gain"}, int'(gain), g);
  endtask

  // one tick-high cycle; returns at the falling edge after it
  task automatic tk();
    fs_tick = 1'b1;
    @(negedge clk);
    fs_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fs_tick = 1'b0;
    stby_n = 1'b1; mute_n = 1'b1; err_n = 1'b1;
    mask_stby = 1'b0; mask_mute = 1'b0; mask_err = 1'b0;
    fw_active = 1'b0; fw_stop = 1'b0; nsup_en = 1'b0; bpz_ext = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk_out("R1 reset", 0, M_GND, 0);

    // activation with extension off, tick-by-tick ramp sweep
    fw_active = 1'b1;
    idle(1);
    chk_out("R2 start", 1, M_MOD, 0);
    for (int i = 1; i <= ACT + RAMP + 2; i++) begin
      int exp_g;
      tk();
      exp_g = (i <= ACT) ? 0 : (((i - ACT) < RAMP) ? (i - ACT) : RAMP);
      check("R3 ramp gain", int'(gain), exp_g);
      check("R2 enable during ramp", int'(pwm_en), 1);
    end

    // mute pin: no tick means no change, then ramp down and back up
    mute_n = 1'b0;
    idle(4);
    check("R4 gain without tick", int'(gain), RAMP);
    for (int i = 1; i <= 3; i++) begin
      tk();
      check("R5 mute ramp down", int'(gain), RAMP - i);
      check("R5 enable held", int'(pwm_en), 1);
    end
    mute_n = 1'b1;
    idle(4);
    check("R4 gain still without tick", int'(gain), RAMP - 3);
    for (int i = 1; i <= 4; i++) begin
      tk();
      check("R5 unmute ramp up", int'(gain), ((RAMP - 3 + i) < RAMP) ? (RAMP - 3 + i) : RAMP);
    end

    // masked mute pin
    mask_mute = 1'b1;
    mute_n = 1'b0;
    idle(4);
    tk(); tk();
    check("R12 masked mute", int'(gain), RAMP);
    mute_n = 1'b1;
    mask_mute = 1'b0;
    idle(3);

    // firmware standby, no noise suppression, no extension
    fw_active = 1'b0;
    idle(1);
    chk_out("R6 mute entry", 1, M_MOD, RAMP);
    for (int j = 1; j <= RAMP; j++) begin
      tk();
      if (j < RAMP) chk_out("R6 mute ramp", 1, M_MOD, RAMP - j);
      else          chk_out("R7 clear skipped to bipolar zero", 1, M_BPZ, 0);
    end
    fw_active = 1'b1;
    for (int k = 1; k <= BPZ; k++) begin
      tk();
      if (k < BPZ) chk_out("R11 bpz continues despite activate", 1, M_BPZ, 0);
      else         chk_out("R8 enable and ground together", 0, M_GND, 0);
    end
    idle(1);
    chk_out("R11 deferred activation", 1, M_MOD, 0);
    for (int i = 1; i <= ACT + RAMP; i++) tk();
    check("R3 full scale again", int'(gain), RAMP);

    // error pin through synchronizer
    err_n = 1'b0;
    idle(2);
    chk_out("R13 error not yet seen", 1, M_MOD, RAMP);
    idle(1);
    chk_out("R10 error stop", 0, M_GND, 0);
    idle(4);
    tk(); tk(); tk();
    chk_out("R10 stop held", 0, M_GND, 0);
    err_n = 1'b1;
    idle(3);
    chk_out("R10 release to standby", 0, M_GND, 0);
    idle(1);
    chk_out("R10 restart after release", 1, M_MOD, 0);

    // masked error pin
    for (int i = 1; i <= ACT; i++) tk();
    mask_err = 1'b1;
    err_n = 1'b0;
    idle(5);
    chk_out("R12 masked error", 1, M_MOD, 0);
    err_n = 1'b1;
    idle(3);
    mask_err = 1'b0;

    // firmware stop
    fw_stop = 1'b1;
    idle(1);
    chk_out("R10 firmware stop", 0, M_GND, 0);
    fw_stop = 1'b0;
    idle(1);
    chk_out("R10 firmware stop release", 0, M_GND, 0);
    idle(1);
    chk_out("R10 firmware restart", 1, M_MOD, 0);

    // pin standby with noise suppression and extension
    for (int i = 1; i <= ACT + 2; i++) tk();
    check("R3 partial ramp", int'(gain), 2);
    nsup_en = 1'b1;
    bpz_ext = 1'b1;
    stby_n = 1'b0;
    idle(2);
    chk_out("R13 standby not yet seen", 1, M_MOD, 2);
    idle(1);
    chk_out("R6 standby pin mute entry", 1, M_MOD, 2);
    tk();
    chk_out("R6 short mute", 1, M_MOD, 1);
    tk();
    chk_out("R7 clear phase entry", 1, M_MOD, 0);
    for (int c = 1; c <= CLR; c++) begin
      tk();
      if (c < CLR) chk_out("R7 clear phase", 1, M_MOD, 0);
      else         chk_out("R7 clear to bipolar zero", 1, M_BPZ, 0);
    end
    for (int b = 1; b <= BPZ; b++) begin
      tk();
      if (b < BPZ) chk_out("R8 bpz phase", 1, M_BPZ, 0);
      else         chk_out("R9 post interval entry", 0, M_BPZ, 0);
    end
    for (int e = 1; e <= EXT; e++) begin
      tk();
      if (e < EXT) chk_out("R9 post interval", 0, M_BPZ, 0);
      else         chk_out("R9 post to ground", 0, M_GND, 0);
    end
    idle(3);
    chk_out("R6 standby pin holds", 0, M_GND, 0);

    // masked standby pin, activation with pre interval
    mask_stby = 1'b1;
    idle(1);
    chk_out("R12 masked standby / R9 pre interval", 0, M_BPZ, 0);
    for (int p = 1; p <= EXT; p++) begin
      tk();
      if (p < EXT) chk_out("R9 pre interval", 0, M_BPZ, 0);
      else         chk_out("R9 pre to start", 1, M_MOD, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule